// File: doc/BRIEF.md
# I/O Port Permission Checker

This block rules on a single I/O port access by the running task: it either lets the access go ahead or reports that a general-protection fault is due. A fault from this block always carries error code zero. The block takes the operating mode, the code segment selector, the flags register, the port number and the access size, and it acts on a one-cycle start strobe.

The block compares privilege levels first. The current level comes from the code segment selector. The I/O level comes from the flags register. If the current level is privileged enough, or the processor is in real mode, the access is allowed at once. If not, the block fetches the task's port permission bitmap over a simple request/acknowledge read port. It fetches a 16-bit word so that a span crossing a byte boundary needs only one read. It then tests every bit that the access covers.

A bitmap that is too short for the port also causes a fault, and in that case no read is issued. Each accepted start gives exactly one single-cycle result pulse.

Top module: `io_perm_gate`

## Requirements
- R1: The current level is `cs_sel[1:0]` and the I/O level is `flags[13:12]`, with a lower number meaning more privilege. In a non-real mode with current <= I/O level, `allow` pulses one cycle after start and no read is made.
- R2: In real mode (`mode` = 2'b00), `allow` pulses one cycle after start whatever the privilege levels are, with no read.
- R3: In protected (2'b01), long (2'b10) or reserved (2'b11, treated as protected) mode with current > I/O level, the outcome comes from the bitmap.
- R4: The bitmap read raises `rd_req` one cycle after start, with `rd_addr` = `bitmap_base` + `port_num[15:3]`. Both `rd_req` and `rd_addr` hold steady until a cycle with `rd_ack` high, and `rd_req` drops after that cycle.
- R5: `rd_data` is little-endian: bit k of the word is the bit for port (`port_num` & ~7) + k. Bits `port_num[2:0]` upward, one per byte accessed, are tested. If any of them is 1, `fault` pulses one cycle after the acknowledge; otherwise `allow` pulses then.
- R6: `size` 2'b00 covers one port byte, 2'b01 two, and 2'b10 or 2'b11 four.
- R7: When the bitmap is needed and `port_num[15:3]` + 1 > `io_limit`, `fault` pulses one cycle after start and no read is made.
- R8: `allow` and `fault` are never high together. Each accepted start yields exactly one of them, for one cycle.
- R9: A start that arrives while a bitmap read is outstanding is ignored.
- R10: After reset, `allow`, `fault` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle request to check an access |
| mode | input | 2 | 00 real, 01 protected, 10 long, 11 treated as protected |
| cs_sel | input | 16 | Code segment selector; low two bits give current privilege |
| flags | input | 32 | Flags register; bits 13:12 give the I/O privilege level |
| port_num | input | 16 | First port of the access |
| size | input | 2 | Access size code (R6) |
| bitmap_base | input | ADDR_W | Byte address of the permission bitmap |
| io_limit | input | LIM_W | Highest byte offset allowed for the second byte of a bitmap read |
| rd_req | output | 1 | Bitmap read request |
| rd_addr | output | ADDR_W | Byte address of the 16-bit bitmap word |
| rd_ack | input | 1 | Read acknowledge, valid with rd_data |
| rd_data | input | 16 | Bitmap word, lower address in the low byte |
| allow | output | 1 | One-cycle pulse: access may proceed |
| fault | output | 1 | One-cycle pulse: general-protection fault, code zero |

## Verification
The privileged path, the real-mode path and the short-bitmap path all report on the clock edge that samples start, so their pulse is due one cycle after the start strobe. On the bitmap path, `rd_req` is due one cycle after start, and the outcome is due one cycle after the edge that samples `rd_ack`. The bench's memory model answers after a set latency, so that due cycle is start + 1 + latency. The driver stamps each expected outcome with its due cycle, and the monitor compares both the kind of pulse and the cycle it arrives in. Any pulse that arrives with no expectation queued is reported, and that is how ignored starts are checked.

// File: rtl/io_perm_gate.sv
module io_perm_gate #(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [15:0]       cs_sel,
  input  logic [31:0]       flags,
  input  logic [15:0]       port_num,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] bitmap_base,
  input  logic [LIM_W-1:0]  io_limit,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [15:0]       rd_data,
  output logic              allow,
  output logic              fault
);

  localparam logic [1:0] MODE_REAL = 2'b00;
  localparam int OFF_W = 13;

  logic              busy;
  logic [2:0]        bit_q;
  logic [3:0]        mask_q;
  logic [ADDR_W-1:0] addr_q;

  logic [1:0]       cpl, iopl;
  logic             priv_ok, over, hit;
  logic [OFF_W-1:0] byte_off;
  logic [LIM_W:0]   need;
  logic [3:0]       span;
  logic [15:0]      shifted;

  assign cpl      = cs_sel[1:0];
  assign iopl     = flags[13:12];
  assign priv_ok  = (mode == MODE_REAL) || (cpl <= iopl);
  assign byte_off = port_num[15:3];
  assign need     = (LIM_W+1)'(byte_off) + (LIM_W+1)'(1);
  assign over     = need > {1'b0, io_limit};
  assign span     = (size == 2'b00) ? 4'b0001 : (size == 2'b01) ? 4'b0011 : 4'b1111;
  assign shifted  = rd_data >> bit_q;
  assign hit      = |(shifted[3:0] & mask_q);

  assign rd_req  = busy;
  assign rd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      allow  <= 1'b0;
      fault  <= 1'b0;
      bit_q  <= '0;
      mask_q <= '0;
      addr_q <= '0;
    end else begin
      allow <= 1'b0;
      fault <= 1'b0;
      if (!busy && start) begin
        if (priv_ok) begin
          allow <= 1'b1;
        end else if (over) begin
          fault <= 1'b1;
        end else begin
          busy   <= 1'b1;
          addr_q <= bitmap_base + ADDR_W'(byte_off);
          bit_q  <= port_num[2:0];
          mask_q <= span;
        end
      end else if (busy && rd_ack) begin
        busy <= 1'b0;
        if (hit) fault <= 1'b1;
        else     allow <= 1'b1;
      end
    end
  end

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(allow && fault));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  // R2
  real_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !rd_req && mode == MODE_REAL |=> allow && !rd_req);

  // R7
  limit_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !rd_req && mode != MODE_REAL && cpl > iopl && over |=> fault && !rd_req);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> !allow && !fault);

  // R3
  read_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> $past(start));

endmodule

// File: tb/io_perm_gate_tb.sv
module io_perm_gate_tb;
  localparam int ADDR_W = 32;
  localparam int LIM_W  = 16;
  localparam logic [ADDR_W-1:0] BASE = 32'h0000_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [15:0] cs_sel = 16'h0;
  logic [31:0] flags = 32'h0;
  logic [15:0] port_num = 16'h0;
  logic [1:0] size = 2'b00;
  logic [LIM_W-1:0] io_limit = 16'd63;
  logic rd_req, rd_ack = 1'b0;
  logic [ADDR_W-1:0] rd_addr;
  logic [15:0] rd_data = 16'h0;
  logic allow, fault;

  io_perm_gate #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .cs_sel(cs_sel),
    .flags(flags), .port_num(port_num), .size(size), .bitmap_base(BASE),
    .io_limit(io_limit), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .allow(allow), .fault(fault));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, lat = 1, wcnt = 0;
  bit exp_read = 1'b0;
  logic [ADDR_W-1:0] exp_addr = '0;
  logic [7:0] mem [0:63];
  int kind_q[$];
  int due_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit bm_bit(input int p);
    return mem[p >> 3][p & 7];
  endfunction

  always @(negedge clk) begin
    if (rd_ack) begin
      rd_ack = 1'b0;
    end else if (rst_n && rd_req) begin
      if (wcnt == 0) chk(exp_read, "R7", "read issued", 1, 0);
      wcnt++;
      if (wcnt >= lat) begin
        chk(rd_addr == exp_addr, "R4", "read address", int'(rd_addr), int'(exp_addr));
        rd_data = {mem[(rd_addr - BASE + 1) & 63], mem[(rd_addr - BASE) & 63]};
        rd_ack = 1'b1;
        wcnt = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && (allow || fault)) begin
      if (allow && fault) chk(1'b0, "R8", "both pulses", 1, 0);
      else if (kind_q.size() == 0) chk(1'b0, "R9", "unexpected pulse", int'(allow), -1);
      else begin
        int k, d;
        string t;
        k = kind_q.pop_front();
        d = due_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(allow) == k, t, "allow(1)/fault(0)", int'(allow), k);
        chk(cyc == d, t, "result cycle", cyc, d);
      end
    end
  end

  task automatic launch(input logic [1:0] m, input logic [1:0] cpl, input logic [1:0] iopl,
                        input logic [15:0] p, input logic [1:0] sz, input string tag, input bit track);
    bit fast, rd, flt;
    int n;
    fast = (m == 2'b00) || (cpl <= iopl);
    rd = !fast && ((int'(p) >> 3) + 1 <= int'(io_limit));
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    flt = !fast && !rd;
    if (rd) for (int i = 0; i < n; i++) if (bm_bit(int'(p) + i)) flt = 1'b1;
    @(negedge clk);
    mode = m;
    cs_sel = 16'h0a38 | {14'h0, cpl};
    flags = 32'h0000_0202 | ({30'h0, iopl} << 12);
    port_num = p;
    size = sz;
    start = 1'b1;
    if (track) begin
      kind_q.push_back(flt ? 0 : 1);
      due_q.push_back(cyc + 1 + (rd ? lat : 0));
      tag_q.push_back(tag);
      exp_read = rd;
      exp_addr = BASE + ADDR_W'(int'(p) >> 3);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_wait();
    int t = 0;
    while (kind_q.size() != 0 && t < 100) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    exp_read = 1'b0;
  endtask

  task automatic run(input logic [1:0] m, input logic [1:0] cpl, input logic [1:0] iopl,
                     input logic [15:0] p, input logic [1:0] sz, input string tag);
    launch(m, cpl, iopl, p, sz, tag, 1'b1);
    finish_wait();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    mem[1] = 8'h08;
    mem[2] = 8'h01;
    mem[4] = 8'h02;
    repeat (3) @(negedge clk);
    chk(!allow && !fault && !rd_req, "R10", "reset outputs", int'({allow, fault, rd_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!allow && !fault && !rd_req, "R10", "idle after reset", int'({allow, fault, rd_req}), 0);

    run(2'b01, 2'd0, 2'd0, 16'd11, 2'b00, "R1");
    run(2'b01, 2'd2, 2'd3, 16'd16, 2'b10, "R1");
    run(2'b10, 2'd1, 2'd1, 16'd33, 2'b01, "R1");
    run(2'b00, 2'd3, 2'd0, 16'd11, 2'b00, "R2");
    run(2'b01, 2'd3, 2'd0, 16'd10, 2'b00, "R5");
    run(2'b01, 2'd3, 2'd0, 16'd11, 2'b00, "R5");
    run(2'b11, 2'd3, 2'd2, 16'd11, 2'b00, "R3");
    run(2'b01, 2'd3, 2'd0, 16'd8,  2'b10, "R6");
    run(2'b01, 2'd3, 2'd0, 16'd12, 2'b11, "R6");
    run(2'b01, 2'd3, 2'd0, 16'd14, 2'b00, "R6");
    run(2'b01, 2'd3, 2'd0, 16'd15, 2'b01, "R5");
    run(2'b10, 2'd3, 2'd1, 16'd30, 2'b10, "R3");
    run(2'b10, 2'd2, 2'd0, 16'd34, 2'b10, "R3");
    run(2'b01, 2'd3, 2'd0, 16'd32, 2'b01, "R6");
    lat = 3;
    run(2'b01, 2'd3, 2'd0, 16'd40, 2'b00, "R4");
    run(2'b01, 2'd3, 2'd0, 16'd33, 2'b00, "R4");
    io_limit = 16'd4;
    run(2'b01, 2'd3, 2'd0, 16'd40, 2'b00, "R7");
    run(2'b01, 2'd3, 2'd0, 16'd24, 2'b00, "R7");
    run(2'b01, 2'd0, 2'd0, 16'd400, 2'b00, "R7");
    io_limit = 16'd63;
    launch(2'b01, 2'd3, 2'd0, 16'd20, 2'b00, "R9", 1'b1);
    launch(2'b00, 2'd0, 2'd3, 16'd11, 2'b00, "R9", 1'b0);
    finish_wait();
    run(2'b01, 2'd3, 2'd0, 16'd11, 2'b00, "R8");
    chk(kind_q.size() == 0, "R8", "missing outcomes", kind_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule